// File: doc/BRIEF.md
# Double-Precision Compare Flag Generator

This block compares two IEEE 754 binary64 values and turns the result into a three-bit condition code. The code is held in registered zero, parity and carry flags. The overflow, sign and auxiliary-carry flags are driven low on every compare. A mode input picks one of two variants. The ordered variant treats any NaN as an invalid operation. The quiet variant treats only a signalling NaN as invalid. The block also reports subnormal operands through a denormal status bit.

The caller presents both operands, the mode and the two exception masks, then pulses `inValid` for one cycle. On the next clock edge the exception status bits are registered and `done` goes high for one cycle. The condition flags are also written on that edge, unless a raised exception has its mask cleared. In that case the flags keep the value from the last compare that was written.

Top module: `fcmp_flags`

## Requirements
- R1: For ordered, non-NaN operands, {zf,pf,cf} becomes 3'b000 when opA > opB, 3'b001 when opA < opB and 3'b100 when they are equal.
- R2: When either operand is a NaN (exponent all ones, fraction nonzero), {zf,pf,cf} becomes 3'b111.
- R3: of, sf and af read 0 after reset and after every completed compare.
- R4: With unorderedMode = 0, excInvalid is set when either operand is a quiet NaN (fraction bit 51 set) or a signalling NaN (fraction bit 51 clear).
- R5: With unorderedMode = 1, excInvalid is set only when an operand is a signalling NaN. A quiet NaN leaves it clear.
- R6: excDenormal is set when either operand is subnormal (exponent zero, fraction nonzero). A subnormal operand is still compared by its value.
- R7: When a raised exception has its mask input low, the flags keep their previous value. When every raised exception is masked, the flags are updated. The status bits are written on every compare.
- R8: Only bits [63:0] of each operand take part. Bits above 63 have no effect.
- R9: +0 and -0 compare as equal (3'b100).
- R10: Flags, status and done are registered on the clock edge at which inValid is sampled high. done is high for exactly one cycle per strobe. A synchronous reset clears every flag, status bit and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Start-of-compare strobe |
| opA | input | 128 | First operand; the low 64 bits are used |
| opB | input | 128 | Second operand; the low 64 bits are used |
| unorderedMode | input | 1 | 0: ordered (any NaN is invalid); 1: quiet (only a signalling NaN is invalid) |
| maskInvalid | input | 1 | 1 masks the invalid exception |
| maskDenormal | input | 1 | 1 masks the denormal exception |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag, always 0 |
| sf | output | 1 | Sign flag, always 0 |
| af | output | 1 | Auxiliary-carry flag, always 0 |
| excInvalid | output | 1 | Invalid-operation status of the last compare |
| excDenormal | output | 1 | Denormal status of the last compare |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle:
- the flag code is always one of the four legal values;
- of, sf and af stay low;
- a NaN operand on a committed compare gives 111;
- a quiet compare with no signalling NaN never raises invalid;
- a suppressed write leaves the flags stable;
- done follows each strobe by exactly one cycle.

The bench scenarios cover the behaviour those properties cannot see on their own. These are the numeric ordering of normal and subnormal values, zero equality, independence from the upper operand bits, and the interaction of the masks with flag holding over a sequence of compares.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  parameter int FP_W   = 64;
  parameter int EXP_W  = 11;
  parameter int FRAC_W = FP_W - EXP_W - 1;
  parameter int QUIET_BIT = FRAC_W - 1;

  typedef struct packed {
    logic capture;   // latch status, pulse done
    logic commit;    // write condition flags
  } fcmp_strobe_t;

  typedef struct packed {
    logic isNan;
    logic isSnan;
    logic isQnan;
    logic isSub;
    logic isZero;
  } fp_class_t;

  function automatic fp_class_t classify(input logic [FP_W-1:0] v);
    fp_class_t c;
    logic expOnes, expZero, fracNz;
    expOnes  = &v[FP_W-2 -: EXP_W];
    expZero  = ~|v[FP_W-2 -: EXP_W];
    fracNz   = |v[FRAC_W-1:0];
    c.isNan  = expOnes & fracNz;
    c.isQnan = c.isNan & v[QUIET_BIT];
    c.isSnan = c.isNan & ~v[QUIET_BIT];
    c.isSub  = expZero & fracNz;
    c.isZero = expZero & ~fracNz;
    return c;
  endfunction

  // Sign-magnitude to monotonic unsigned key
  function automatic logic [FP_W-1:0] orderKey(input logic [FP_W-1:0] v);
    return v[FP_W-1] ? ~v : {1'b1, v[FP_W-2:0]};
  endfunction
endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         rawInvalid,
  input  logic         rawDenormal,
  input  logic         maskInvalid,
  input  logic         maskDenormal,
  output fcmp_strobe_t strobe,
  output logic         done
);
  logic unmaskedHit;

  always_comb begin
    unmaskedHit    = (rawInvalid & ~maskInvalid) | (rawDenormal & ~maskDenormal);
    strobe.capture = inValid;
    strobe.commit  = inValid & ~unmaskedHit;
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= inValid;
  end

  // R10: done follows each strobe one cycle later, and only then
  p_done_after_valid_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> done);
  p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !done);
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int OPND_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic              unorderedMode,
  input  fcmp_strobe_t      strobe,
  output logic              rawInvalid,
  output logic              rawDenormal,
  output logic              zf,
  output logic              pf,
  output logic              cf,
  output logic              of,
  output logic              sf,
  output logic              af,
  output logic              excInvalid,
  output logic              excDenormal
);
  logic [FP_W-1:0] lowA, lowB, keyA, keyB;
  fp_class_t       clsA, clsB;
  logic            anyNan, anySnan, isEq, isLt;
  logic [2:0]      code;

  always_comb begin
    lowA   = opA[FP_W-1:0];
    lowB   = opB[FP_W-1:0];
    clsA   = classify(lowA);
    clsB   = classify(lowB);
    keyA   = orderKey(lowA);
    keyB   = orderKey(lowB);
    anyNan  = clsA.isNan  | clsB.isNan;
    anySnan = clsA.isSnan | clsB.isSnan;
    isEq   = (keyA == keyB) | (clsA.isZero & clsB.isZero);
    isLt   = ~isEq & (keyA < keyB);
    if (anyNan)    code = 3'b111;
    else if (isEq) code = 3'b100;
    else if (isLt) code = 3'b001;
    else           code = 3'b000;
    rawInvalid  = unorderedMode ? anySnan : anyNan;
    rawDenormal = clsA.isSub | clsB.isSub;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {zf, pf, cf} <= 3'b000;
      {of, sf, af} <= 3'b000;
      excInvalid   <= 1'b0;
      excDenormal  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        excInvalid  <= rawInvalid;
        excDenormal <= rawDenormal;
        {of, sf, af} <= 3'b000;
      end
      if (strobe.commit) {zf, pf, cf} <= code;
    end
  end

  // R1: flags always hold one of the four legal codes
  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    ({zf, pf, cf} inside {3'b000, 3'b001, 3'b100, 3'b111}));
  // R2: a committed compare with a NaN yields the unordered code
  p_nan_unordered_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && anyNan) |=> ({zf, pf, cf} == 3'b111));
  // R3: overflow, sign and aux flags never set
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    !(of || sf || af));
  // R5: quiet mode with no signalling NaN never reports invalid
  p_quiet_no_invalid_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && unorderedMode && !anySnan) |=> !excInvalid);
  // R7: suppressed write keeps the flags
  p_hold_on_unmasked_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.commit) |=> $stable({zf, pf, cf}));
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int OPND_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic              unorderedMode,
  input  logic              maskInvalid,
  input  logic              maskDenormal,
  output logic              zf,
  output logic              pf,
  output logic              cf,
  output logic              of,
  output logic              sf,
  output logic              af,
  output logic              excInvalid,
  output logic              excDenormal,
  output logic              done
);
  fcmp_strobe_t strobe;
  logic         rawInvalid, rawDenormal;

  fcmp_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .inValid      (inValid),
    .rawInvalid   (rawInvalid),
    .rawDenormal  (rawDenormal),
    .maskInvalid  (maskInvalid),
    .maskDenormal (maskDenormal),
    .strobe       (strobe),
    .done         (done)
  );

  fcmp_datapath #(.OPND_W(OPND_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .opA           (opA),
    .opB           (opB),
    .unorderedMode (unorderedMode),
    .strobe        (strobe),
    .rawInvalid    (rawInvalid),
    .rawDenormal   (rawDenormal),
    .zf            (zf),
    .pf            (pf),
    .cf            (cf),
    .of            (of),
    .sf            (sf),
    .af            (af),
    .excInvalid    (excInvalid),
    .excDenormal   (excDenormal)
  );
endmodule

// File: tb/fcmp_flags_tb.sv
module fcmp_flags_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic         unorderedMode = 1'b0, maskInvalid = 1'b1, maskDenormal = 1'b1;
  logic         zf, pf, cf, of, sf, af, excInvalid, excDenormal, done;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [2:0] expFlags = 3'b000;

  always #10 clk = ~clk;  // 50 MHz

  fcmp_flags dut_i (.*);

  function automatic bit isNan(input logic [63:0] v);
    return (&v[62:52]) && (|v[51:0]);
  endfunction
  function automatic bit isSnan(input logic [63:0] v);
    return isNan(v) && !v[51];
  endfunction
  function automatic bit isSub(input logic [63:0] v);
    return (v[62:52] == 11'd0) && (|v[51:0]);
  endfunction
  function automatic logic [2:0] refCode(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (isNan(a) || isNan(b)) return 3'b111;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra > rb) return 3'b000;
    if (ra < rb) return 3'b001;
    return 3'b100;
  endfunction

  function automatic logic [63:0] genOp(input int cls);
    logic [63:0] v;
    v[63] = 1'($urandom);
    v[51:0] = {20'($urandom), 32'($urandom)};
    case (cls)
      0: begin v[62:52] = 11'd0; v[51:0] = '0; end
      1: begin v[62:52] = 11'd0; if (v[51:0] == 0) v[0] = 1'b1; end
      2: v[62:52] = 11'd1 + 11'($urandom_range(2045));
      3: begin v[62:52] = '1; v[51:0] = '0; end
      4: begin v[62:52] = '1; v[51] = 1'b1; end
      default: begin v[62:52] = '1; v[51] = 1'b0; if (v[50:0] == 0) v[3] = 1'b1; end
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doCompare(input logic [127:0] a, input logic [127:0] b,
                           input logic um, input logic mi, input logic md,
                           input string tag);
    logic expInv, expDen;
    @(negedge clk);
    opA = a; opB = b; unorderedMode = um; maskInvalid = mi; maskDenormal = md;
    inValid = 1'b1;
    expInv = um ? (isSnan(a[63:0]) || isSnan(b[63:0])) : (isNan(a[63:0]) || isNan(b[63:0]));
    expDen = isSub(a[63:0]) || isSub(b[63:0]);
    if (!((expInv && !mi) || (expDen && !md))) expFlags = refCode(a[63:0], b[63:0]);
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " flags"}, {29'd0, zf, pf, cf}, {29'd0, expFlags});
    check("R4/R5 invalid", {31'd0, excInvalid}, {31'd0, expInv});
    check("R6 denormal", {31'd0, excDenormal}, {31'd0, expDen});
    check("R3 of/sf/af", {29'd0, of, sf, af}, 32'd0);
    check("R10 done high", {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SUBN = 64'h0000_0000_0000_0003;
  localparam logic [63:0] NSUB = 64'h8000_0000_0000_0005;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 reset flags", {23'd0, zf, pf, cf, of, sf, af, excInvalid, excDenormal, done}, 32'd0);

    doCompare({64'd0, ONE}, {64'd0, TWO}, 0, 1, 1, "R1 less");
    doCompare({64'd0, TWO}, {64'd0, ONE}, 0, 1, 1, "R1 greater");
    doCompare({64'd0, TWO}, {64'd0, TWO}, 0, 1, 1, "R1 equal");
    doCompare({64'd0, PZ},  {64'd0, NZ},  0, 1, 1, "R9 zero equal");
    doCompare({64'd0, NZ},  {64'd0, PZ},  1, 1, 1, "R9 zero equal");
    doCompare({64'd0, QNAN}, {64'd0, ONE}, 0, 1, 1, "R2/R4 qnan ordered");
    doCompare({64'd0, ONE}, {64'd0, QNAN}, 1, 1, 1, "R2/R5 qnan quiet");
    doCompare({64'd0, SNAN}, {64'd0, ONE}, 1, 1, 1, "R2/R5 snan quiet");
    doCompare({64'd0, ONE}, {64'd0, TWO}, 0, 1, 1, "R1 less");
    doCompare({64'd0, SNAN}, {64'd0, ONE}, 0, 0, 1, "R7 hold on invalid");
    doCompare({64'd0, QNAN}, {64'd0, TWO}, 1, 0, 1, "R7 quiet qnan unmasked updates");
    doCompare({64'd0, SUBN}, {64'd0, PZ}, 0, 1, 1, "R6 subnormal greater");
    doCompare({64'd0, NSUB}, {64'd0, SUBN}, 0, 1, 1, "R6 subnormal less");
    doCompare({64'd0, SUBN}, {64'd0, TWO}, 0, 1, 0, "R7 hold on denormal");
    doCompare({64'hDEAD_BEEF_0000_0001, ONE}, {64'h1234_5678_9ABC_DEF0, ONE}, 0, 1, 1, "R8 upper ignored");
    doCompare({64'hFFFF_FFFF_FFFF_FFFF, TWO}, {64'd0, ONE}, 0, 1, 1, "R8 upper ignored");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = genOp($urandom_range(5));
      b = ($urandom_range(7) == 0) ? a : genOp($urandom_range(5));
      doCompare({64'($urandom), a}, {64'($urandom), b}, 1'($urandom),
                1'($urandom_range(3) != 0), 1'($urandom_range(3) != 0), "R1/R2/R7 random");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears", {23'd0, zf, pf, cf, of, sf, af, excInvalid, excDenormal, done}, 32'd0);
    rst = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule